// File: doc/BRIEF.md
# Clock Output Stop and Enable Gating Bank

This block sits between the clock dividers of a system clock generator and its output pins. It takes one source clock per output group (CPU, SDRAM, PCI, AGP, reference, 48 MHz and a 24 MHz alternate) and produces the gated output bank: 3 CPU, 13 SDRAM, 6 PCI (index 0 free-running), 2 AGP, 2 reference, one 48 MHz and one selectable 24/48 MHz clock. Each output is turned on or off by its own enable bit from the configuration register. Group stop pins and a power-down pin can force it low as well.

A strap-level mode input decides what four shared pins do. In desktop mode they carry SDRAM outputs 8 to 11. In mobile mode they become active-low inputs: power-down, SDRAM stop, PCI stop and CPU stop. Every stop or enable change passes through a two-flop synchronizer in the output's own clock domain. It is then applied by a falling-edge gate flop, so an output starts and stops only while its clock is low. Power-down enters asynchronously and leaves through the same synchronized path.

Top module: `clk_stop_bank`

## Requirements
- R1: With its enable bit at 1 an output follows its source clock; with the bit at 0 it is held low and does not toggle.
- R2: An enable or stop change applied after a rising edge P0 leaves the output unchanged during the high phases after rising edges P1 and P2 and takes effect from rising edge P3. The gate only changes while the source clock is low.
- R3: With mode_i = 0, shared_oe_o is 1, sdr_o[11:8] run under their enable bits, and shared_i has no effect on any output.
- R4: With mode_i = 1, shared_oe_o is 0 and sdr_o[11:8] are held low. shared_i bit 0 is power-down, bit 1 is SDRAM stop, bit 2 is PCI stop and bit 3 is CPU stop, all active low.
- R5: In mobile mode a low CPU stop holds cpu_o[1:0] low, and holds cpu_o[2] low when cpu2_free_i = 0.
- R6: With cpu2_free_i = 1, cpu_o[2] keeps running while the CPU stop is low.
- R7: In mobile mode a low PCI stop holds pci_o[5:1] low; pci_o[0] is unaffected by it.
- R8: In mobile mode a low SDRAM stop holds all enabled SDRAM outputs low.
- R9: The AGP, reference, 48 MHz and 24/48 MHz outputs are never affected by any stop input.
- R10: In mobile mode a low power-down input forces every clock output low at once, without waiting for a clock edge. After release, outputs resume with the R2 latency.
- R11: The 24/48 MHz output is driven from clk_24_i when sel24_i = 1 and from clk_48_i when sel24_i = 0, under en_2448_i.
- R12: While rst_ni is low every clock output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_cpu_i | input | 1 | CPU group source clock |
| clk_sdr_i | input | 1 | SDRAM group source clock |
| clk_pci_i | input | 1 | PCI group source clock |
| clk_agp_i | input | 1 | AGP group source clock |
| clk_ref_i | input | 1 | Reference source clock |
| clk_48_i | input | 1 | 48 MHz source clock |
| clk_24_i | input | 1 | 24 MHz source clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = desktop, 1 = mobile |
| shared_i | input | 4 | Shared pin inputs: [0] power-down, [1] SDRAM stop, [2] PCI stop, [3] CPU stop (mobile only) |
| cpu2_free_i | input | 1 | 1 = cpu_o[2] ignores the CPU stop |
| sel24_i | input | 1 | 1 = 24 MHz, 0 = 48 MHz on the selectable output |
| en_cpu_i | input | 3 | CPU output enables |
| en_sdr_i | input | 13 | SDRAM output enables |
| en_pci_i | input | 6 | PCI output enables, bit 0 free-running |
| en_agp_i | input | 2 | AGP output enables |
| en_ref_i | input | 2 | Reference output enables |
| en_48_i | input | 1 | 48 MHz output enable |
| en_2448_i | input | 1 | 24/48 MHz output enable |
| cpu_o | output | 3 | Gated CPU clocks |
| sdr_o | output | 13 | Gated SDRAM clocks |
| pci_o | output | 6 | Gated PCI clocks |
| agp_o | output | 2 | Gated AGP clocks |
| ref_o | output | 2 | Gated reference clocks |
| c48_o | output | 1 | Gated 48 MHz clock |
| c2448_o | output | 1 | Gated 24/48 MHz clock |
| shared_oe_o | output | 1 | 1 = shared pins drive sdr_o[11:8] |

## Verification
The assertions sample each group on the falling edge of its own source clock. They assume that enables, stops and the mode strap are quasi-static: a level that is seen on four falling edges in a row must have held across the rising edges between them. The mode input must also not change while clocks are running. The stimulus changes every control one time unit after a rising edge, changes the mode only with settling cycles around it, and sets sel24_i only with long gaps, so the assumed windows hold.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  localparam int N_CPU      = 3;
  localparam int N_SDR      = 13;
  localparam int N_PCI      = 6;
  localparam int N_AGP      = 2;
  localparam int N_REF      = 2;
  localparam int SHARED_LO  = 8;
  localparam int N_SHARED   = 4;
  localparam int SYNC_DEPTH = 2;
  localparam int CPU_FREE_IDX = 2;
  // shared pin roles in mobile mode
  localparam int PIN_PD   = 0;
  localparam int PIN_SDR  = 1;
  localparam int PIN_PCI  = 2;
  localparam int PIN_CPU  = 3;
endpackage

// File: rtl/clk_gate_cell.sv
module clk_gate_cell #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic en_i,
  output logic clk_o
);
  logic [SYNC-1:0] sync_q;
  logic            gate_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[SYNC-2:0], en_i};
  end

  // falling-edge update: gate only moves while clk_i is low
  always_ff @(negedge clk_i or negedge arst_ni) begin
    if (!arst_ni) gate_q <= 1'b0;
    else          gate_q <= sync_q[SYNC-1];
  end

  assign clk_o = clk_i & gate_q;
endmodule

// File: rtl/clk_gate_group.sv
module clk_gate_group #(
  parameter int N    = 2,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         arst_ni,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] clk_o
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    clk_gate_cell #(.SYNC(SYNC)) u_cell (
      .clk_i  (clk_i),
      .arst_ni(arst_ni),
      .en_i   (en_i[g]),
      .clk_o  (clk_o[g])
    );
  end
endmodule

// File: rtl/clk_stop_bank.sv
module clk_stop_bank
  import clk_stop_pkg::*;
(
  input  logic                clk_cpu_i,
  input  logic                clk_sdr_i,
  input  logic                clk_pci_i,
  input  logic                clk_agp_i,
  input  logic                clk_ref_i,
  input  logic                clk_48_i,
  input  logic                clk_24_i,
  input  logic                rst_ni,
  input  logic                mode_i,
  input  logic [N_SHARED-1:0] shared_i,
  input  logic                cpu2_free_i,
  input  logic                sel24_i,
  input  logic [N_CPU-1:0]    en_cpu_i,
  input  logic [N_SDR-1:0]    en_sdr_i,
  input  logic [N_PCI-1:0]    en_pci_i,
  input  logic [N_AGP-1:0]    en_agp_i,
  input  logic [N_REF-1:0]    en_ref_i,
  input  logic                en_48_i,
  input  logic                en_2448_i,
  output logic [N_CPU-1:0]    cpu_o,
  output logic [N_SDR-1:0]    sdr_o,
  output logic [N_PCI-1:0]    pci_o,
  output logic [N_AGP-1:0]    agp_o,
  output logic [N_REF-1:0]    ref_o,
  output logic                c48_o,
  output logic                c2448_o,
  output logic                shared_oe_o
);
  logic pd_act, arst_n;
  logic cpu_run, sdr_run, pci_run;
  logic [N_CPU-1:0] cpu_en;
  logic [N_SDR-1:0] sdr_en;
  logic [N_PCI-1:0] pci_en;
  logic c24_part, c48_part;

  assign pd_act  = mode_i & ~shared_i[PIN_PD];
  assign arst_n  = rst_ni & ~pd_act;
  assign cpu_run = ~mode_i | shared_i[PIN_CPU];
  assign sdr_run = ~mode_i | shared_i[PIN_SDR];
  assign pci_run = ~mode_i | shared_i[PIN_PCI];
  assign shared_oe_o = ~mode_i;

  always_comb begin
    for (int i = 0; i < N_CPU; i++)
      cpu_en[i] = en_cpu_i[i] & (cpu_run | ((i == CPU_FREE_IDX) & cpu2_free_i));
    for (int i = 0; i < N_SDR; i++)
      sdr_en[i] = en_sdr_i[i] & sdr_run &
                  ~(mode_i & (i >= SHARED_LO) & (i < SHARED_LO + N_SHARED));
    for (int i = 0; i < N_PCI; i++)
      pci_en[i] = en_pci_i[i] & ((i == 0) | pci_run);
  end

  clk_gate_group #(.N(N_CPU), .SYNC(SYNC_DEPTH)) u_cpu (
    .clk_i(clk_cpu_i), .arst_ni(arst_n), .en_i(cpu_en), .clk_o(cpu_o));
  clk_gate_group #(.N(N_SDR), .SYNC(SYNC_DEPTH)) u_sdr (
    .clk_i(clk_sdr_i), .arst_ni(arst_n), .en_i(sdr_en), .clk_o(sdr_o));
  clk_gate_group #(.N(N_PCI), .SYNC(SYNC_DEPTH)) u_pci (
    .clk_i(clk_pci_i), .arst_ni(arst_n), .en_i(pci_en), .clk_o(pci_o));
  clk_gate_group #(.N(N_AGP), .SYNC(SYNC_DEPTH)) u_agp (
    .clk_i(clk_agp_i), .arst_ni(arst_n), .en_i(en_agp_i), .clk_o(agp_o));
  clk_gate_group #(.N(N_REF), .SYNC(SYNC_DEPTH)) u_ref (
    .clk_i(clk_ref_i), .arst_ni(arst_n), .en_i(en_ref_i), .clk_o(ref_o));

  clk_gate_cell #(.SYNC(SYNC_DEPTH)) u_c48 (
    .clk_i(clk_48_i), .arst_ni(arst_n), .en_i(en_48_i), .clk_o(c48_o));

  // selectable output: one gate per source, at most one enabled
  clk_gate_cell #(.SYNC(SYNC_DEPTH)) u_sel24 (
    .clk_i(clk_24_i), .arst_ni(arst_n), .en_i(en_2448_i & sel24_i), .clk_o(c24_part));
  clk_gate_cell #(.SYNC(SYNC_DEPTH)) u_sel48 (
    .clk_i(clk_48_i), .arst_ni(arst_n), .en_i(en_2448_i & ~sel24_i), .clk_o(c48_part));

  assign c2448_o = c24_part | c48_part;
endmodule

// File: rtl/clk_stop_bank_chk.sv
module clk_stop_bank_chk
  import clk_stop_pkg::*;
(
  input logic                clk_cpu_i,
  input logic                clk_sdr_i,
  input logic                clk_pci_i,
  input logic                clk_agp_i,
  input logic                rst_ni,
  input logic                mode_i,
  input logic [N_SHARED-1:0] shared_i,
  input logic                cpu2_free_i,
  input logic [N_CPU-1:0]    en_cpu_i,
  input logic [N_PCI-1:0]    en_pci_i,
  input logic [N_AGP-1:0]    en_agp_i,
  input logic [N_CPU-1:0]    cpu_o,
  input logic [N_SDR-1:0]    sdr_o,
  input logic [N_PCI-1:0]    pci_o,
  input logic [N_AGP-1:0]    agp_o,
  input logic [N_REF-1:0]    ref_o,
  input logic                c48_o
);
  logic arst_ok, cstop, pstop, pd;
  assign pd      = mode_i & ~shared_i[PIN_PD];
  assign arst_ok = rst_ni & ~pd;
  assign cstop   = mode_i & ~shared_i[PIN_CPU];
  assign pstop   = mode_i & ~shared_i[PIN_PCI];

  // R1
  off_low_chk: assert property (@(negedge clk_cpu_i) disable iff (!rst_ni)
    (!en_cpu_i[1] && !$past(en_cpu_i[1]) && !$past(en_cpu_i[1], 2) && !$past(en_cpu_i[1], 3))
    |-> !cpu_o[1]);

  // R4
  shared_low_chk: assert property (@(negedge clk_sdr_i) disable iff (!rst_ni)
    (mode_i && $past(mode_i) && $past(mode_i, 2) && $past(mode_i, 3))
    |-> (sdr_o[SHARED_LO+N_SHARED-1:SHARED_LO] == '0));

  // R5
  cpu_stop_chk: assert property (@(negedge clk_cpu_i) disable iff (!rst_ni)
    (cstop && $past(cstop) && $past(cstop, 2) && $past(cstop, 3)) |-> !cpu_o[0]);

  // R6
  cpu2_free_chk: assert property (@(negedge clk_cpu_i) disable iff (!rst_ni)
    (cpu2_free_i && $past(cpu2_free_i) && $past(cpu2_free_i, 2) && $past(cpu2_free_i, 3) &&
     en_cpu_i[2] && $past(en_cpu_i[2]) && $past(en_cpu_i[2], 2) && $past(en_cpu_i[2], 3) &&
     arst_ok && $past(arst_ok) && $past(arst_ok, 2) && $past(arst_ok, 3)) |-> cpu_o[2]);

  // R7
  pci_free_chk: assert property (@(negedge clk_pci_i) disable iff (!rst_ni)
    (pstop && en_pci_i[0] && $past(en_pci_i[0]) && $past(en_pci_i[0], 2) && $past(en_pci_i[0], 3) &&
     arst_ok && $past(arst_ok) && $past(arst_ok, 2) && $past(arst_ok, 3)) |-> pci_o[0]);

  // R9
  agp_run_chk: assert property (@(negedge clk_agp_i) disable iff (!rst_ni)
    (en_agp_i[0] && $past(en_agp_i[0]) && $past(en_agp_i[0], 2) && $past(en_agp_i[0], 3) &&
     arst_ok && $past(arst_ok) && $past(arst_ok, 2) && $past(arst_ok, 3)) |-> agp_o[0]);

  // R10
  pd_low_chk: assert property (@(negedge clk_cpu_i) disable iff (!rst_ni)
    pd |-> (cpu_o == '0 && sdr_o == '0 && pci_o == '0 && agp_o == '0 && ref_o == '0 && !c48_o));
endmodule

bind clk_stop_bank clk_stop_bank_chk u_chk (.*);

// File: tb/clk_stop_bank_bench.sv
module clk_stop_bank_bench;
  logic clk = 1'b0;
  logic clk24 = 1'b0;
  logic rst_ni, mode, cpu2_free, sel24, en_48, en_2448;
  logic [3:0]  shared;
  logic [2:0]  en_cpu;
  logic [12:0] en_sdr;
  logic [5:0]  en_pci;
  logic [1:0]  en_agp, en_ref;
  logic [2:0]  cpu_o;
  logic [12:0] sdr_o;
  logic [5:0]  pci_o;
  logic [1:0]  agp_o, ref_o;
  logic c48_o, c2448_o, shared_oe_o;

  int checks = 0;
  int failures = 0;
  int edge_cnt = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    bit          is_cnt;
    logic [27:0] exp;
    int          cnt;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) clk24 <= ~clk24;
  always @(posedge c2448_o) edge_cnt <= edge_cnt + 1;

  clk_stop_bank u_clk_stop_bank (
    .clk_cpu_i(clk), .clk_sdr_i(clk), .clk_pci_i(clk), .clk_agp_i(clk),
    .clk_ref_i(clk), .clk_48_i(clk), .clk_24_i(clk24),
    .rst_ni(rst_ni), .mode_i(mode), .shared_i(shared), .cpu2_free_i(cpu2_free),
    .sel24_i(sel24), .en_cpu_i(en_cpu), .en_sdr_i(en_sdr), .en_pci_i(en_pci),
    .en_agp_i(en_agp), .en_ref_i(en_ref), .en_48_i(en_48), .en_2448_i(en_2448),
    .cpu_o(cpu_o), .sdr_o(sdr_o), .pci_o(pci_o), .agp_o(agp_o), .ref_o(ref_o),
    .c48_o(c48_o), .c2448_o(c2448_o), .shared_oe_o(shared_oe_o));

  function automatic logic [27:0] observed();
    return {shared_oe_o, ref_o, agp_o, pci_o, sdr_o, cpu_o, c48_o};
  endfunction

  // expected levels during a high phase, from the requirements
  function automatic logic [27:0] model();
    logic pd, cs, ss, ps, live;
    logic [2:0] c; logic [12:0] s; logic [5:0] p;
    pd = mode && !shared[0];
    ss = mode && !shared[1];
    ps = mode && !shared[2];
    cs = mode && !shared[3];
    live = rst_ni && !pd;
    for (int i = 0; i < 3; i++) c[i] = live && en_cpu[i] && (!cs || (i == 2 && cpu2_free));
    for (int i = 0; i < 13; i++) s[i] = live && en_sdr[i] && !ss && !(mode && i >= 8 && i <= 11);
    for (int i = 0; i < 6; i++) p[i] = live && en_pci[i] && (i == 0 || !ps);
    return {!mode, en_ref & {2{live}}, en_agp & {2{live}}, p, s, c, en_48 && live};
  endfunction

  task automatic check(string tag, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_vec(string tag);
    item_t it;
    it.tag = tag; it.is_cnt = 0; it.exp = model(); it.cnt = 0;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic expect_cnt(string tag, int n);
    item_t it;
    it.tag = tag; it.is_cnt = 1; it.exp = '0; it.cnt = n;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  // monitor
  initial begin
    forever begin
      item_t it;
      wait (sb_q.size() != 0);
      @(posedge clk); #1;
      it = sb_q[0];
      if (!it.is_cnt) begin
        check(it.tag, observed(), it.exp);
      end else begin
        edge_cnt = 0;
        repeat (20) @(posedge clk);
        #1;
        check(it.tag, 28'(edge_cnt), 28'(it.cnt));
      end
      void'(sb_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; mode = 0; shared = 4'hF; cpu2_free = 0; sel24 = 0;
    en_cpu = '1; en_sdr = '1; en_pci = '1; en_agp = '1; en_ref = '1;
    en_48 = 1; en_2448 = 1;
    settle(3);
    expect_vec("R12 reset");
    rst_ni = 1;
    settle(5);
    expect_vec("R1 all enabled");
    en_cpu = 3'b010; en_sdr = 13'h0A5C; en_pci = 6'b101010; en_agp = 2'b01; en_ref = 2'b10; en_48 = 0;
    settle(5);
    expect_vec("R1 mixed enables");
    en_cpu = '1; en_sdr = '1; en_pci = '1; en_agp = '1; en_ref = '1; en_48 = 1;
    shared = 4'b0001;
    settle(5);
    expect_vec("R3 desktop ignores shared");
    shared = 4'hF; mode = 1;
    settle(5);
    expect_vec("R4 mobile shared low");
    shared = 4'b0111;
    settle(5);
    expect_vec("R5 cpu stop");
    cpu2_free = 1;
    settle(5);
    expect_vec("R6 cpu2 free");
    cpu2_free = 0; shared = 4'b1011;
    settle(5);
    expect_vec("R7 pci stop");
    shared = 4'b1101;
    settle(5);
    expect_vec("R8 sdram stop");
    shared = 4'b0001;
    settle(5);
    expect_vec("R9 all stops");
    expect_cnt("R9 24/48 under stops", 20);
    shared = 4'b1110;
    #1;
    check("R10 async entry", observed(), 28'h0);
    settle(2);
    expect_vec("R10 power-down");
    shared = 4'hF;
    settle(5);
    expect_vec("R10 resume");
    mode = 0;
    settle(5);
    expect_cnt("R11 48 MHz source", 20);
    sel24 = 1;
    settle(12);
    expect_cnt("R11 24 MHz source", 10);
    en_2448 = 0;
    settle(12);
    expect_cnt("R1 24/48 disabled", 0);
    // R2 latency: change one time unit after rising edge P0
    en_cpu[0] = 0;
    settle(5);
    en_cpu[0] = 1;
    settle(1);
    check("R2 P1 still low", 28'(cpu_o[0]), 28'd0);
    settle(1);
    check("R2 P2 still low", 28'(cpu_o[0]), 28'd0);
    settle(1);
    check("R2 P3 running", 28'(cpu_o[0]), 28'd1);
    en_cpu[0] = 0;
    settle(1);
    check("R2 P1 still high", 28'(cpu_o[0]), 28'd1);
    settle(1);
    check("R2 P2 still high", 28'(cpu_o[0]), 28'd1);
    settle(1);
    check("R2 P3 stopped", 28'(cpu_o[0]), 28'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule